// File: doc/BRIEF.md
# Display window addressing command generator

This block turns a request to refresh a rectangular region of a page-organised monochrome display into the byte stream that a display controller expects. The stream first positions the controller's write pointer with command bytes, then carries the pixel bytes. Each byte leaves with a command/data flag on a valid/ready handshake. The rectangle is given as a column start, a width in columns, a start page (the row divided by eight) and a page count. Fixed column and page offsets, set by parameters, are added to the start positions.

Two addressing modes are supported. In window mode the block sends a column-range command and a page-range command, then all pixel bytes in one burst. It remembers the last ranges it sent and leaves out a range command that would repeat them. In page mode each page is preceded by a three-byte positioning group: page select, then the low column nibble, then the high column nibble. A parameter forces page mode for controllers that support only that mode. Pixel bytes are passed through from an upstream byte source. A one-cycle done pulse marks the end of each update.

Top module: `disp_win_seq`

## Requirements
- R1: In window mode the column-range command is the byte 0x21, then start = (req_col + COL_OFFSET) mod 256, then end = (start + req_width - 1) mod 256. All three bytes carry out_is_cmd = 1.
- R2: In window mode the page-range command follows the column-range command. It is the byte 0x22, then start = (req_page + PAGE_OFFSET) mod 256, then end = (start + req_pages - 1) mod 256. All three bytes carry out_is_cmd = 1.
- R3: Each range command is left out when its start and end both equal the last ones the block sent. The two ranges are compared independently. Reset clears the remembered ranges, so the first window-mode update sends both commands.
- R4: In window mode exactly req_width*req_pages data bytes (out_is_cmd = 0) follow the range commands, in one burst. Each data byte equals px_data at its handshake.
- R5: In page mode, before each page i (0-based), the block sends three command bytes in this order: 0xB0 OR ((start page + i) mod 8), then 0x00 OR column start bits [3:0], then 0x10 OR column start bits [7:4]. The starts are formed as in R1 and R2. Exactly req_width data bytes follow each group.
- R6: With PAGE_ONLY = 1 every update uses page mode, whatever req_pmode is (req_pmode = 1 selects page mode, 0 selects window mode).
- R7: The default offsets are COL_OFFSET = 0 and PAGE_OFFSET = 1.
- R8: done is high for exactly one cycle, the cycle after the handshake of the update's last data byte. req_ready is high only while no update is in progress, and no byte is offered during that time.
- R9: A command byte offered without out_ready stays offered, unchanged, until it is accepted.
- R10: Page-mode updates leave the remembered ranges unchanged.
- R11: After reset req_ready = 1, out_valid = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Update request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_col | input | 8 | First column of the rectangle |
| req_width | input | LEN_W | Width in columns (at least 1) |
| req_page | input | 8 | First page (row / 8) |
| req_pages | input | PGN_W | Number of pages (at least 1) |
| req_pmode | input | 1 | 1 = page mode, 0 = window mode |
| px_data | input | 8 | Pixel byte from upstream |
| px_valid | input | 1 | Pixel byte valid |
| px_ready | output | 1 | Pixel byte taken |
| out_byte | output | 8 | Outgoing command or data byte |
| out_is_cmd | output | 1 | 1 = command byte, 0 = data byte |
| out_valid | output | 1 | Outgoing byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| done | output | 1 | Update finished pulse |

## Verification
A request placed before a clock edge is accepted on that edge. Its first command byte is offered in the next cycle. Each skipped range command costs one cycle with nothing offered. done rises in the cycle after the last data handshake. Because stalls move every byte after the first, the bench checks the order and content of the handshaken stream rather than fixed cycle numbers. It checks the done pulse exactly: the cycle number of the last data handshake plus one. Hold behaviour under back-pressure is checked on every stalled command cycle while downstream readiness toggles.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;
   localparam logic [7:0] OP_COLRNG = 8'h21;
   localparam logic [7:0] OP_PGRNG  = 8'h22;
   localparam logic [7:0] OP_PGSEL  = 8'hB0;
   localparam logic [7:0] OP_COLLO  = 8'h00;
   localparam logic [7:0] OP_COLHI  = 8'h10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLW,
      ST_PGW,
      ST_POS,
      ST_DATA
   } seq_st_t;

   typedef struct packed {
      logic [7:0] lo;
      logic [7:0] hi;
   } span_t;
endpackage

// File: rtl/disp_win_cache.sv
module disp_win_cache
   import disp_win_pkg::*;
#(
   parameter int NENT = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  span_t    [NENT-1:0]   span_in,
   input  logic     [NENT-1:0]   upd,
   output logic     [NENT-1:0]   hit
);
   for (genvar g = 0; g < NENT; g++) begin : g_ent
      span_t held;
      logic  vld;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held <= '0;
            vld  <= 1'b0;
         end else if (upd[g]) begin
            held <= span_in[g];
            vld  <= 1'b1;
         end
      end
      assign hit[g] = vld && (held == span_in[g]);
   end
endmodule

// File: rtl/disp_win_fsm.sv
module disp_win_fsm
   import disp_win_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int PGN_W       = 4,
   parameter bit PAGE_ONLY   = 1'b0,
   parameter int COL_OFFSET  = 0,
   parameter int PAGE_OFFSET = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [7:0]       req_col,
   input  logic [LEN_W-1:0] req_width,
   input  logic [7:0]       req_page,
   input  logic [PGN_W-1:0] req_pages,
   input  logic             req_pmode,
   input  logic [7:0]       px_data,
   input  logic             px_valid,
   output logic             px_ready,
   output logic [7:0]       out_byte,
   output logic             out_is_cmd,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             done,
   output span_t            col_span,
   output span_t            pg_span,
   output logic             col_upd,
   output logic             pg_upd,
   input  logic             col_hit,
   input  logic             pg_hit
);
   localparam logic [7:0] COL_OFS8 = 8'(COL_OFFSET);
   localparam logic [7:0] PG_OFS8  = 8'(PAGE_OFFSET);

   seq_st_t          st;
   logic [1:0]       sub;
   span_t            col_q, pg_q;
   logic [LEN_W-1:0] wid_q, ccnt;
   logic [PGN_W-1:0] npg_q, pcnt;
   logic             pm_q;

   logic [7:0] col_lo_n, pg_lo_n, pg_cur;
   logic       pm_sel, hs, last_col, last_pg;

   assign pm_sel   = req_pmode | PAGE_ONLY;
   assign col_lo_n = COL_OFS8 + req_col;
   assign pg_lo_n  = PG_OFS8 + req_page;
   assign pg_cur   = pg_q.lo + 8'(pcnt);
   assign hs       = out_valid && out_ready;
   assign last_col = (ccnt == wid_q - LEN_W'(1));
   assign last_pg  = (pcnt == npg_q - PGN_W'(1));
   assign req_ready = (st == ST_IDLE);
   assign col_span  = col_q;
   assign pg_span   = pg_q;

   always_comb begin
      out_valid  = 1'b0;
      out_is_cmd = 1'b1;
      out_byte   = '0;
      px_ready   = 1'b0;
      col_upd    = 1'b0;
      pg_upd     = 1'b0;
      unique case (st)
         ST_COLW: begin
            out_valid = !col_hit;
            out_byte  = (sub == 2'd0) ? OP_COLRNG : (sub == 2'd1) ? col_q.lo : col_q.hi;
            col_upd   = hs && (sub == 2'd2);
         end
         ST_PGW: begin
            out_valid = !pg_hit;
            out_byte  = (sub == 2'd0) ? OP_PGRNG : (sub == 2'd1) ? pg_q.lo : pg_q.hi;
            pg_upd    = hs && (sub == 2'd2);
         end
         ST_POS: begin
            out_valid = 1'b1;
            out_byte  = (sub == 2'd0) ? (OP_PGSEL | {5'd0, pg_cur[2:0]}) :
                        (sub == 2'd1) ? (OP_COLLO | {4'd0, col_q.lo[3:0]}) :
                                        (OP_COLHI | {4'd0, col_q.lo[7:4]});
         end
         ST_DATA: begin
            out_valid  = px_valid;
            out_is_cmd = 1'b0;
            out_byte   = px_data;
            px_ready   = out_ready;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         sub   <= '0;
         col_q <= '0;
         pg_q  <= '0;
         wid_q <= '0;
         npg_q <= '0;
         ccnt  <= '0;
         pcnt  <= '0;
         pm_q  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               col_q.lo <= col_lo_n;
               col_q.hi <= col_lo_n + 8'(req_width) - 8'd1;
               pg_q.lo  <= pg_lo_n;
               pg_q.hi  <= pg_lo_n + 8'(req_pages) - 8'd1;
               wid_q    <= req_width;
               npg_q    <= req_pages;
               pm_q     <= pm_sel;
               sub      <= '0;
               ccnt     <= '0;
               pcnt     <= '0;
               st       <= pm_sel ? ST_POS : ST_COLW;
            end
            ST_COLW: begin
               if (col_hit) begin
                  sub <= '0;
                  st  <= ST_PGW;
               end else if (hs) begin
                  if (sub == 2'd2) begin
                     sub <= '0;
                     st  <= ST_PGW;
                  end else sub <= sub + 2'd1;
               end
            end
            ST_PGW: begin
               if (pg_hit) begin
                  sub <= '0;
                  st  <= ST_DATA;
               end else if (hs) begin
                  if (sub == 2'd2) begin
                     sub <= '0;
                     st  <= ST_DATA;
                  end else sub <= sub + 2'd1;
               end
            end
            ST_POS: if (hs) begin
               if (sub == 2'd2) begin
                  sub <= '0;
                  st  <= ST_DATA;
               end else sub <= sub + 2'd1;
            end
            ST_DATA: if (hs) begin
               if (last_col) begin
                  ccnt <= '0;
                  if (last_pg) begin
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end else begin
                     pcnt <= pcnt + PGN_W'(1);
                     st   <= pm_q ? ST_POS : ST_DATA;
                  end
               end else ccnt <= ccnt + LEN_W'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/disp_win_seq.sv
module disp_win_seq
   import disp_win_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int PGN_W       = 4,
   parameter bit PAGE_ONLY   = 1'b0,
   parameter int COL_OFFSET  = 0,
   parameter int PAGE_OFFSET = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [7:0]       req_col,
   input  logic [LEN_W-1:0] req_width,
   input  logic [7:0]       req_page,
   input  logic [PGN_W-1:0] req_pages,
   input  logic             req_pmode,
   input  logic [7:0]       px_data,
   input  logic             px_valid,
   output logic             px_ready,
   output logic [7:0]       out_byte,
   output logic             out_is_cmd,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             done
);
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("LEN_W must be 1..8");
   end
   if (PGN_W < 1 || PGN_W > 8) begin : g_bad_pgn
      $error("PGN_W must be 1..8");
   end
   if (COL_OFFSET < 0 || COL_OFFSET > 255 || PAGE_OFFSET < 0 || PAGE_OFFSET > 255) begin : g_bad_ofs
      $error("offsets must fit in a byte");
   end

   span_t       col_span, pg_span;
   logic        col_upd, pg_upd;
   logic [1:0]  hit;

   disp_win_fsm #(
      .LEN_W(LEN_W), .PGN_W(PGN_W), .PAGE_ONLY(PAGE_ONLY),
      .COL_OFFSET(COL_OFFSET), .PAGE_OFFSET(PAGE_OFFSET)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_col(req_col), .req_width(req_width),
      .req_page(req_page), .req_pages(req_pages), .req_pmode(req_pmode),
      .px_data(px_data), .px_valid(px_valid), .px_ready(px_ready),
      .out_byte(out_byte), .out_is_cmd(out_is_cmd),
      .out_valid(out_valid), .out_ready(out_ready), .done(done),
      .col_span(col_span), .pg_span(pg_span),
      .col_upd(col_upd), .pg_upd(pg_upd),
      .col_hit(hit[0]), .pg_hit(hit[1])
   );

   disp_win_cache #(.NENT(2)) u_cache (
      .clk(clk), .rst_n(rst_n),
      .span_in({pg_span, col_span}),
      .upd({pg_upd, col_upd}),
      .hit(hit)
   );
endmodule

// File: rtl/disp_win_chk.sv
module disp_win_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [7:0] px_data,
   input logic [7:0] out_byte,
   input logic       out_is_cmd,
   input logic       out_valid,
   input logic       out_ready,
   input logic       done
);
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !out_valid); // R8
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready && !out_is_cmd)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_is_cmd && !out_ready |=> out_valid && out_is_cmd && $stable(out_byte)); // R9
   AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_is_cmd |-> out_byte == px_data); // R4
endmodule

bind disp_win_seq disp_win_chk u_chk (.*);

// File: tb/disp_win_seq_bench.sv
`timescale 1ns/1ps
module disp_win_seq_bench;
   localparam int CO = 0;   // R7 default column offset
   localparam int PO = 1;   // R7 default page offset

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic       req_valid, sel;
   logic [7:0] req_col, req_page;
   logic [7:0] req_width;
   logic [3:0] req_pages;
   logic       req_pmode;
   logic [7:0] px_data;
   logic       out_ready, stall;

   logic       rr0, pr0, oc0, ov0, dn0, rr1, pr1, oc1, ov1, dn1;
   logic [7:0] ob0, ob1;

   disp_win_seq u_disp_win_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid & ~sel), .req_ready(rr0),
      .req_col(req_col), .req_width(req_width), .req_page(req_page),
      .req_pages(req_pages), .req_pmode(req_pmode),
      .px_data(px_data), .px_valid(1'b1), .px_ready(pr0),
      .out_byte(ob0), .out_is_cmd(oc0), .out_valid(ov0), .out_ready(out_ready & ~sel),
      .done(dn0));

   disp_win_seq #(.PAGE_ONLY(1'b1)) u_disp_win_seq_po (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid & sel), .req_ready(rr1),
      .req_col(req_col), .req_width(req_width), .req_page(req_page),
      .req_pages(req_pages), .req_pmode(req_pmode),
      .px_data(px_data), .px_valid(1'b1), .px_ready(pr1),
      .out_byte(ob1), .out_is_cmd(oc1), .out_valid(ov1), .out_ready(out_ready & sel),
      .done(dn1));

   wire       o_rr = sel ? rr1 : rr0;
   wire       o_pr = sel ? pr1 : pr0;
   wire [7:0] o_b  = sel ? ob1 : ob0;
   wire       o_c  = sel ? oc1 : oc0;
   wire       o_v  = sel ? ov1 : ov0;
   wire       o_d  = sel ? dn1 : dn0;

   always @(posedge clk) begin
      if (o_pr) px_data <= px_data + 8'd1;
      out_ready <= stall ? ~out_ready : 1'b1;
   end

   int ntests = 0, nfail = 0;
   int cyc = 0, last_hs = -10, done_cyc = -10, ndone = 0, hold_bad = 0, hold_seen = 0;
   logic       prev_stall_cmd = 1'b0;
   logic [7:0] prev_byte = '0;
   logic [8:0] got_q[$];
   logic [8:0] exp_q[$];

   // model of the remembered ranges (R3, R10)
   bit         cv = 0, pv = 0;
   logic [7:0] cs_m, ce_m, ps_m, pe_m;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (o_v && out_ready) begin
            got_q.push_back({o_c, o_b});
            if (!o_c) last_hs = cyc;
         end
         if (o_d) begin
            done_cyc = cyc;
            ndone++;
         end
         if (prev_stall_cmd) begin
            hold_seen++;
            if (!(o_v && o_c && o_b == prev_byte)) hold_bad++;
         end
         prev_stall_cmd = o_v && o_c && !out_ready;
         prev_byte = o_b;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   endtask

   task automatic run_update(input int col, input int w, input int pg, input int np,
                             input bit pm, input bit inst1, input string rq);
      logic [7:0] base, cs, ce, ps, pe;
      int         k, tmo;
      bit         pmode;
      base  = px_data;
      pmode = inst1 | pm;
      cs = 8'(col + CO);
      ce = 8'(cs + w - 1);
      ps = 8'(pg + PO);
      pe = 8'(ps + np - 1);
      exp_q.delete();
      k = 0;
      if (!pmode) begin
         if (!cv || cs != cs_m || ce != ce_m) begin   // R1
            exp_q.push_back(9'h121); exp_q.push_back({1'b1, cs}); exp_q.push_back({1'b1, ce});
            cv = 1; cs_m = cs; ce_m = ce;
         end
         if (!pv || ps != ps_m || pe != pe_m) begin   // R2
            exp_q.push_back(9'h122); exp_q.push_back({1'b1, ps}); exp_q.push_back({1'b1, pe});
            pv = 1; ps_m = ps; pe_m = pe;
         end
         for (int i = 0; i < w * np; i++) exp_q.push_back({1'b0, 8'(base + i)});
      end else begin
         for (int i = 0; i < np; i++) begin           // R5
            logic [7:0] pc;
            pc = 8'(ps + i);
            exp_q.push_back({1'b1, 8'hB0 | {5'd0, pc[2:0]}});
            exp_q.push_back({1'b1, {4'h0, cs[3:0]}});
            exp_q.push_back({1'b1, {4'h1, cs[7:4]}});
            for (int j = 0; j < w; j++) begin
               exp_q.push_back({1'b0, 8'(base + k)});
               k++;
            end
         end
      end
      got_q.delete();
      ndone = 0;
      hold_bad = 0;
      hold_seen = 0;
      sel = inst1;
      req_col = 8'(col); req_width = 8'(w); req_page = 8'(pg); req_pages = 4'(np);
      req_pmode = pm;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      tmo = 0;
      while (ndone == 0 && tmo < 3000) begin
         @(negedge clk);
         tmo++;
      end
      chk(tmo < 3000, rq, "watchdog done wait", tmo, 0);
      @(negedge clk); @(negedge clk);
      chk(got_q.size() == exp_q.size(), rq, "stream length", got_q.size(), exp_q.size());
      begin
         int bad = -1;
         for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
         if (bad >= 0)
            chk(0, rq, $sformatf("stream byte %0d ({cmd,byte})", bad), int'(got_q[bad]), int'(exp_q[bad]));
         else
            chk(1, rq, "stream content", 0, 0);
      end
      chk(done_cyc == last_hs + 1, "R8", "done cycle after last data", done_cyc, last_hs + 1);
      chk(ndone == 1, "R8", "done pulse count", ndone, 1);
      chk(o_rr == 1'b1, "R8", "req_ready back when idle", int'(o_rr), 1);
   endtask

   task automatic t_reset();
      chk(rr0 == 1 && rr1 == 1, "R11", "req_ready after reset", int'({rr1, rr0}), 3);
      chk(ov0 == 0 && ov1 == 0, "R11", "out_valid after reset", int'({ov1, ov0}), 0);
      chk(dn0 == 0 && dn1 == 0, "R11", "done after reset", int'({dn1, dn0}), 0);
   endtask

   task automatic t_first_window();   // R1 R2 R4 R7, both commands after reset (R3)
      run_update(3, 4, 0, 2, 1'b0, 1'b0, "R1/R2/R4/R7");
   endtask

   task automatic t_repeat_window();  // R3 both skipped
      run_update(3, 4, 0, 2, 1'b0, 1'b0, "R3 repeat");
   endtask

   task automatic t_page_change();    // R3 only page range sent
      run_update(3, 4, 2, 1, 1'b0, 1'b0, "R3 page-only change");
   endtask

   task automatic t_page_mode();      // R5 page number wraps mod 8
      run_update(8'h1A, 3, 6, 3, 1'b1, 1'b0, "R5");
   endtask

   task automatic t_after_page();     // R10 cache untouched by page mode
      run_update(3, 4, 2, 1, 1'b0, 1'b0, "R10");
   endtask

   task automatic t_stall_wrap();     // R1 end wraps, R9 hold under stalls
      stall = 1'b1;
      run_update(250, 10, 1, 2, 1'b0, 1'b0, "R1 wrap");
      chk(hold_seen > 0 && hold_bad == 0, "R9", "stalled command bytes held", hold_bad, 0);
      stall = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_page_only();      // R6
      run_update(5, 2, 0, 2, 1'b0, 1'b1, "R6");
      sel = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; sel = 1'b0; stall = 1'b0;
      req_col = '0; req_width = 8'd1; req_page = '0; req_pages = 4'd1; req_pmode = 1'b0;
      px_data = 8'h40; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_window();
      t_repeat_window();
      t_page_change();
      t_page_mode();
      t_after_page();
      t_stall_wrap();
      t_page_only();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule